// File: doc/BRIEF.md
# Protected Region Descriptor Register File

This block stores the region descriptors that a memory-protection checker consults on every bus access. Each region has four 32-bit words: a start address, an end address, a rights word and a control word whose bit 0 marks the region valid. Software reads and writes the descriptors through a simple single-cycle register port. Each write carries the identity of the bus master that issued it, so the block can refuse changes that would take the debugger's access away.

Region 0 is special. Out of reset it spans the whole address space with full rights for every master. Only the debugger (master 1) may move its bounds or alter the debugger's own rights group inside it. A write from any other master to those fields is dropped, in whole or in part. The rest of region 0's rights word, and all of every other region, can be written by any master. A global register holds the checker enable, a read-only code for the number of regions, and one sticky error flag per slave port. The checker raises a flag with a pulse, and software clears it by writing 1.

All descriptor contents are also driven out in parallel to the checker. Addresses are kept at 32-byte granularity.

Top module: `rgn_desc_file`

## Requirements
- R1: After reset, region 0 reads start 0x00000000, end 0xFFFFFFFF, rights 0xFF1C71C7 and control 0x1. Every other region reads start 0x0, end 0x1F, rights 0x0 and control 0x0. The global register reads 0x0, and `rgn_valid` is 0x01.
- R2: Register word address `r*4+w` selects region r, word w (w=0 start, 1 end, 2 rights, 3 control). The address with only its top bit set (0x20 for 8 regions) selects the global register. `rd_data` shows the addressed word combinationally.
- R3: A start address reads back, and appears on `rgn_start`, with bits 4:0 forced to 0. An end address reads back, and appears on `rgn_end`, with bits 4:0 forced to 1. Bits 31:5 keep the written value.
- R4: The rights word of regions 1 and up stores all 32 written bits for any master. Masters 0-3 each own a 6-bit group at bit n*6: bits 2:0 user rights, bits 4:3 supervisor rights, bit 5 process-id enable. Masters 4-7 each own a 2-bit group at bit 24+(n-4)*2. The word is driven on `rgn_rights`.
- R5: Bit 0 of a control word sets or clears that region's valid bit (`rgn_valid[r]`), independently of every other region. The other control bits read 0.
- R6: A write to region 0's start or end word from any master other than master 1 leaves the word unchanged. A write from master 1 takes effect.
- R7: A write to region 0's rights word from any master other than master 1 updates every bit except bits 11:6, the debugger's group, which keep their old value. A write from master 1 updates all bits.
- R8: Global bit 0 is the read/write checker enable (`chk_enable`). Bits 5:4 read the region-count code (0 for 8 regions, 1 for 12, 2 for 16) and ignore writes.
- R9: Global bits 11:8 are the error flags of slave ports 0-3 (`err_flags`). A flag is set by a one-cycle `err_pulse`. It is cleared by writing 1 to its bit. Writing 0 has no effect. When a set and a clear occur in the same cycle, the flag ends up set.
- R10: With `wr_en` low, nothing changes regardless of address, data and master. A write becomes visible on `rd_data` and the descriptor outputs from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register word address for the write |
| wr_data | input | 32 | Write data |
| wr_mstr | input | MSTR_W | Identity of the master issuing the write |
| rd_addr | input | REG_AW | Register word address for the read |
| rd_data | output | 32 | Read data for `rd_addr` |
| err_pulse | input | NUM_PORTS | Per-slave-port error pulses from the checker |
| chk_enable | output | 1 | Global checker enable |
| rgn_valid | output | NUM_REGIONS | Valid bit of each region |
| rgn_start | output | NUM_REGIONS*32 | Start address of each region, region r at bits r*32 |
| rgn_end | output | NUM_REGIONS*32 | End address of each region |
| rgn_rights | output | NUM_REGIONS*32 | Rights word of each region |
| err_flags | output | NUM_PORTS | Sticky slave-port error flags |

## Verification
The hardest case to reach is the partial write to region 0's rights word. The lock depends jointly on region, word, and the writing master, and only bits 11:6 survive. The bench sweeps all eight masters against every region and all four words, with distinct data patterns. It keeps a running model of each word, so locked and unlocked writes interleave and each merge is checked against whatever earlier writes left behind. The collision between an error pulse and a software clear of the same flag is driven in a single cycle, using a flag that is already set.

// File: rtl/prf_pkg.sv
// Shared constants, word selects and reset-value helpers for the
// protected region descriptor register file.
// Assumes 32-bit descriptor words and 32-byte address granularity.
package prf_pkg;

    localparam int WORD_W       = 32;
    localparam int GRAIN_W      = 5;
    localparam int HI_W         = WORD_W - GRAIN_W;
    localparam int PRIV_MASTERS = 4;
    localparam int PRIV_GRP_W   = 6;
    localparam int RW_MASTERS   = 4;
    localparam int RW_BASE      = 24;
    localparam int RW_GRP_W     = 2;

    // Fields of the global register
    localparam int G_EN_BIT   = 0;
    localparam int G_CODE_LSB = 4;
    localparam int G_FLAG_LSB = 8;

    typedef enum logic [1:0] {
        W_START  = 2'd0,
        W_END    = 2'd1,
        W_RIGHTS = 2'd2,
        W_CTRL   = 2'd3
    } word_sel_e;

    // Rights word granting every master every right
    function automatic logic [WORD_W-1:0] full_rights();
        logic [WORD_W-1:0] v;
        v = '0;
        for (int n = 0; n < PRIV_MASTERS; n++) begin
            v[n*PRIV_GRP_W +: PRIV_GRP_W] = 6'b000111;
        end
        for (int n = 0; n < RW_MASTERS; n++) begin
            v[RW_BASE + n*RW_GRP_W +: RW_GRP_W] = 2'b11;
        end
        return v;
    endfunction

    // Encoded region count as reported in the global register
    function automatic logic [1:0] count_code(int n);
        if (n <= 8)       return 2'd0;
        else if (n <= 12) return 2'd1;
        else              return 2'd2;
    endfunction

endpackage

// File: rtl/prf_slot.sv
// One region descriptor: start, end, rights and valid bit.
// When IS_ZERO is set, writes from any master except DEBUG_ID cannot
// change the bounds or the debugger's rights group.
// Assumes the parent decodes the write to this slot into we/sel.
module prf_slot
    import prf_pkg::*;
#(
    parameter bit IS_ZERO  = 1'b0,
    parameter int MSTR_W   = 3,
    parameter int DEBUG_ID = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  word_sel_e         sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [MSTR_W-1:0] wmstr,
    output logic [HI_W-1:0]   start_hi,
    output logic [HI_W-1:0]   end_hi,
    output logic [WORD_W-1:0] rights,
    output logic              valid
);

    localparam logic [WORD_W-1:0] DBG_MASK =
        WORD_W'(6'h3F) << (DEBUG_ID * PRIV_GRP_W);
    localparam logic [HI_W-1:0]   RST_END    = IS_ZERO ? '1 : '0;
    localparam logic [WORD_W-1:0] RST_RIGHTS = IS_ZERO ? full_rights() : '0;
    localparam logic              RST_VALID  = IS_ZERO;

    logic              locked;
    logic [WORD_W-1:0] rights_nx;

    // Writer lacks the debugger identity on a protected slot
    assign locked = IS_ZERO && (wmstr != MSTR_W'(DEBUG_ID));

    // Merge new rights with the preserved debugger group when locked
    always_comb begin
        if (locked) rights_nx = (wdata & ~DBG_MASK) | (rights & DBG_MASK);
        else        rights_nx = wdata;
    end

    // Descriptor storage with per-word write enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_hi <= '0;
            end_hi   <= RST_END;
            rights   <= RST_RIGHTS;
            valid    <= RST_VALID;
        end else if (we) begin
            case (sel)
                W_START:  if (!locked) start_hi <= wdata[WORD_W-1:GRAIN_W];
                W_END:    if (!locked) end_hi   <= wdata[WORD_W-1:GRAIN_W];
                W_RIGHTS: rights <= rights_nx;
                W_CTRL:   valid  <= wdata[0];
                default:  ;
            endcase
        end
    end

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(start_hi) && $stable(end_hi) && $stable(rights) && $stable(valid)));

    // R5
    valid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == W_CTRL) |=> (valid == $past(wdata[0])));

    generate
        if (IS_ZERO) begin : g_lock_chk
            // R6
            r0_bounds_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we && locked && (sel == W_START || sel == W_END))
                |=> ($stable(start_hi) && $stable(end_hi)));

            // R7
            r0_dbg_rights_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (we && locked && sel == W_RIGHTS)
                |=> ((rights & DBG_MASK) == $past(rights & DBG_MASK)));
        end
    endgenerate

endmodule

// File: rtl/prf_glb.sv
// Global control and status: checker enable, region-count code and
// sticky per-slave-port error flags (set by pulse, cleared by write-1).
// Assumes the parent passes only the relevant write-data bits.
module prf_glb
    import prf_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int NUM_REGIONS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 wr_en_bit,
    input  logic [NUM_PORTS-1:0] wr_clr,
    input  logic [NUM_PORTS-1:0] err_pulse,
    output logic                 enable,
    output logic [NUM_PORTS-1:0] flags,
    output logic [WORD_W-1:0]    rdata
);

    localparam logic [1:0] CODE = count_code(NUM_REGIONS);

    // Checker enable register
    always_ff @(posedge clk) begin
        if (!rst_n)  enable <= 1'b0;
        else if (we) enable <= wr_en_bit;
    end

    // Per-port sticky flags, set has priority over clear
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n)            flags[p] <= 1'b0;
                else if (err_pulse[p]) flags[p] <= 1'b1;
                else if (we && wr_clr[p]) flags[p] <= 1'b0;
            end

            // R9
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                err_pulse[p] |=> flags[p]);

            // R9
            no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!flags[p] && !err_pulse[p]) |=> !flags[p]);

            // R9
            flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[p] && !(we && wr_clr[p])) |=> flags[p]);
        end
    endgenerate

    // Assemble the register image for reads
    always_comb begin
        rdata = '0;
        rdata[G_EN_BIT] = enable;
        rdata[G_CODE_LSB +: 2] = CODE;
        rdata[G_FLAG_LSB +: NUM_PORTS] = flags;
    end

    // R8
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(enable));

endmodule

// File: rtl/rgn_desc_file.sv
// Protected region descriptor register file top level.
// Decodes the register port, instantiates one slot per region (slot 0
// protected), the global register, the read mux and the flat outputs.
// Assumes NUM_REGIONS is 8, 12 or 16; unused indices read 0.
module rgn_desc_file
    import prf_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int NUM_PORTS   = 4,
    parameter int MSTR_W      = 3,
    parameter int DEBUG_ID    = 1,
    localparam int RIDX_W     = $clog2(NUM_REGIONS),
    localparam int REG_AW     = RIDX_W + 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [REG_AW-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [MSTR_W-1:0]             wr_mstr,
    input  logic [REG_AW-1:0]             rd_addr,
    output logic [WORD_W-1:0]             rd_data,
    input  logic [NUM_PORTS-1:0]          err_pulse,
    output logic                          chk_enable,
    output logic [NUM_REGIONS-1:0]        rgn_valid,
    output logic [NUM_REGIONS*WORD_W-1:0] rgn_start,
    output logic [NUM_REGIONS*WORD_W-1:0] rgn_end,
    output logic [NUM_REGIONS*WORD_W-1:0] rgn_rights,
    output logic [NUM_PORTS-1:0]          err_flags
);

    logic              wr_glb, rd_glb;
    logic [RIDX_W-1:0] wr_ridx, rd_ridx;
    word_sel_e         wr_word, rd_word;
    logic [WORD_W-1:0] glb_rdata;

    logic [HI_W-1:0]   st_hi [NUM_REGIONS];
    logic [HI_W-1:0]   en_hi [NUM_REGIONS];
    logic [WORD_W-1:0] rt    [NUM_REGIONS];
    logic              vl    [NUM_REGIONS];

    // Split both addresses into global select, region index and word
    assign wr_glb  = wr_addr[REG_AW-1];
    assign wr_ridx = wr_addr[REG_AW-2:2];
    assign wr_word = word_sel_e'(wr_addr[1:0]);
    assign rd_glb  = rd_addr[REG_AW-1];
    assign rd_ridx = rd_addr[REG_AW-2:2];
    assign rd_word = word_sel_e'(rd_addr[1:0]);

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
            logic slot_we;
            assign slot_we = wr_en && !wr_glb && (wr_ridx == RIDX_W'(g));

            prf_slot #(
                .IS_ZERO  (g == 0),
                .MSTR_W   (MSTR_W),
                .DEBUG_ID (DEBUG_ID)
            ) i_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .we       (slot_we),
                .sel      (wr_word),
                .wdata    (wr_data),
                .wmstr    (wr_mstr),
                .start_hi (st_hi[g]),
                .end_hi   (en_hi[g]),
                .rights   (rt[g]),
                .valid    (vl[g])
            );

            // Drive the checker-side copies with the granule bits fixed
            assign rgn_start [g*WORD_W +: WORD_W] = {st_hi[g], {GRAIN_W{1'b0}}};
            assign rgn_end   [g*WORD_W +: WORD_W] = {en_hi[g], {GRAIN_W{1'b1}}};
            assign rgn_rights[g*WORD_W +: WORD_W] = rt[g];
            assign rgn_valid[g] = vl[g];
        end
    endgenerate

    prf_glb #(
        .NUM_PORTS   (NUM_PORTS),
        .NUM_REGIONS (NUM_REGIONS)
    ) i_glb (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en && wr_glb),
        .wr_en_bit (wr_data[G_EN_BIT]),
        .wr_clr    (wr_data[G_FLAG_LSB +: NUM_PORTS]),
        .err_pulse (err_pulse),
        .enable    (chk_enable),
        .flags     (err_flags),
        .rdata     (glb_rdata)
    );

    // Combinational read mux over the global register and all slots
    always_comb begin
        rd_data = '0;
        if (rd_glb) begin
            rd_data = glb_rdata;
        end else if ({1'b0, rd_ridx} < (RIDX_W+1)'(NUM_REGIONS)) begin
            case (rd_word)
                W_START:  rd_data = {st_hi[rd_ridx], {GRAIN_W{1'b0}}};
                W_END:    rd_data = {en_hi[rd_ridx], {GRAIN_W{1'b1}}};
                W_RIGHTS: rd_data = rt[rd_ridx];
                W_CTRL:   rd_data = {{(WORD_W-1){1'b0}}, vl[rd_ridx]};
                default:  rd_data = '0;
            endcase
        end
    end

    // R1
    r0_valid_reset_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (rgn_valid == NUM_REGIONS'(1)));

endmodule

// File: tb/test_rgn_desc_file.sv
// Self-checking bench: sweeps every master over every region word and
// exercises the global register, with a bench-side model of contents.
module test_rgn_desc_file;

    localparam int NR = 8;
    localparam int NP = 4;
    localparam int AW = 6;
    localparam logic [31:0] DBGM   = 32'h0000_0FC0;
    localparam logic [AW-1:0] GADDR = 6'h20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [2:0]    wr_mstr = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] err_pulse = '0;
    logic          chk_enable;
    logic [NR-1:0] rgn_valid;
    logic [NR*32-1:0] rgn_start, rgn_end, rgn_rights;
    logic [NP-1:0] err_flags;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_start [NR];
    logic [31:0] m_end   [NR];
    logic [31:0] m_rt    [NR];
    logic        m_vl    [NR];

    always #4 clk = ~clk;

    rgn_desc_file i_rgn_desc_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mstr(wr_mstr), .rd_addr(rd_addr),
        .rd_data(rd_data), .err_pulse(err_pulse), .chk_enable(chk_enable),
        .rgn_valid(rgn_valid), .rgn_start(rgn_start), .rgn_end(rgn_end),
        .rgn_rights(rgn_rights), .err_flags(err_flags)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic [2:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mstr = m;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_region(int r, string tag);
        logic [31:0] v;
        rd(AW'(r*4+0), v); chk({tag, " start"}, v, m_start[r] & 32'hFFFF_FFE0);
        rd(AW'(r*4+1), v); chk({tag, " end"}, v, m_end[r] | 32'h1F);
        rd(AW'(r*4+2), v); chk({tag, " rights"}, v, m_rt[r]);
        rd(AW'(r*4+3), v); chk({tag, " ctrl"}, v, {31'd0, m_vl[r]});
        chk({tag, " rgn_start"}, rgn_start[r*32 +: 32], m_start[r] & 32'hFFFF_FFE0);
        chk({tag, " rgn_end"}, rgn_end[r*32 +: 32], m_end[r] | 32'h1F);
        chk({tag, " rgn_rights"}, rgn_rights[r*32 +: 32], m_rt[r]);
        chk({tag, " rgn_valid"}, {31'd0, rgn_valid[r]}, {31'd0, m_vl[r]});
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] ds, de, dr, dc;
        for (int r = 0; r < NR; r++) begin
            m_start[r] = 32'h0;
            m_end[r]   = (r == 0) ? 32'hFFFF_FFFF : 32'h0;
            m_rt[r]    = (r == 0) ? 32'hFF1C_71C7 : 32'h0;
            m_vl[r]    = (r == 0);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset image of all regions and global register
        for (int r = 0; r < NR; r++) check_region(r, "R1 reset");
        rd(GADDR, v); chk("R1 global reset", v, 32'h0);
        chk("R1 valid vector", {24'd0, rgn_valid}, 32'h01);

        // R10: a strobe-less cycle with live address/data changes nothing
        @(negedge clk);
        wr_addr = 6'h04; wr_data = 32'hDEAD_BEEF; wr_mstr = 3'd1;
        @(negedge clk);
        check_region(1, "R10 no strobe");

        // R2..R7: every master writes every word of every region
        for (int r = 0; r < NR; r++) begin
            for (int m = 0; m < 8; m++) begin
                bit lk;
                lk = (r == 0) && (m != 1);
                ds = 32'hA5A5_0013 ^ (32'(r) << 20) ^ (32'(m) * 32'h0000_1357);
                de = ds + 32'h0123_4567 + (32'(m) << 27);
                dr = 32'h9E37_79B9 * 32'(r*8 + m + 1);
                dc = 32'hFFFF_FFF0 | 32'((r + m) & 1);
                wr(AW'(r*4+0), ds, 3'(m));
                wr(AW'(r*4+1), de, 3'(m));
                wr(AW'(r*4+2), dr, 3'(m));
                wr(AW'(r*4+3), dc, 3'(m));
                if (!lk) begin
                    m_start[r] = ds;
                    m_end[r]   = de;
                end
                m_rt[r] = lk ? ((dr & ~DBGM) | (m_rt[r] & DBGM)) : dr;
                m_vl[r] = dc[0];
                if (r == 0) check_region(r, lk ? "R6 R7 locked" : "R6 R7 debugger");
                else        check_region(r, "R2 R3 R4 R5 sweep");
            end
        end
        // R5: regions stay independent after the whole sweep
        for (int r = 0; r < NR; r++) check_region(r, "R5 final");

        // R8: enable is read/write, count code ignores writes
        wr(GADDR, 32'hFFFF_FFFF, 3'd0);
        rd(GADDR, v); chk("R8 enable set", v, 32'h1);
        chk("R8 chk_enable", {31'd0, chk_enable}, 32'h1);
        wr(GADDR, 32'h0000_0030, 3'd2);
        rd(GADDR, v); chk("R8 code read-only", v, 32'h0);

        // R9: pulse sets flags 0 and 2
        @(negedge clk); err_pulse = 4'b0101;
        @(negedge clk); err_pulse = 4'b0000;
        rd(GADDR, v); chk("R9 pulse set", v, 32'h500);
        chk("R9 err_flags", {28'd0, err_flags}, 32'h5);
        wr(GADDR, 32'h0000_0000, 3'd0);
        rd(GADDR, v); chk("R9 write zero", v, 32'h500);
        wr(GADDR, 32'h0000_0100, 3'd0);
        rd(GADDR, v); chk("R9 clear one", v, 32'h400);
        // R9: set and clear of flag 2 in one cycle, set wins
        @(negedge clk);
        err_pulse = 4'b0100; wr_en = 1'b1; wr_addr = GADDR;
        wr_data = 32'h0000_0F01; wr_mstr = 3'd0;
        @(negedge clk);
        err_pulse = 4'b0000; wr_en = 1'b0;
        rd(GADDR, v); chk("R9 set wins", v, 32'h401);
        wr(GADDR, 32'h0000_0F00, 3'd0);
        rd(GADDR, v); chk("R9 clear all", v, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule